// File: doc/BRIEF.md
# Dot-Matrix Row Scan Engine

This block turns eight stored character codes into the time-multiplexed drive for a row of eight 5x7 LED characters. A free-running timer on the display clock visits the seven dot rows in turn and gives each row an equal slot. During a slot the block fetches every digit's five dots for the active row and raises one row enable. Each dot pattern comes either from an external built-in glyph lookup, addressed by a 7-bit symbol and the row, or from an external custom-glyph memory, addressed by a 4-bit entry and the row. A tag bit in each character code picks the source. The glyph contents themselves live outside the block.

The dots are then gated three ways. A brightness code limits how long each row slot stays lit. A per-digit flash attribute, used only when flash is enabled, darkens chosen digits during the dark half of a slow period. A whole-display blink darkens all eight digits during the same half and takes priority over flash. The flash and blink phase comes from one shared divider, and a synchronous reset brings the row, slot and divider counters back to zero. Several units that share a clock and a reset therefore scan and blink in step.

Top module: `dotscan_engine`

## Requirements
- R1: The rows are scanned in the order 0,1,...,6 and then back to 0. Each row holds for SLOT_CLKS (32) clocks, so a full refresh takes 224 clocks. `row_en_o` has exactly bit r set while row r is active. The row index is also presented on `glyph_row_o` and `cg_row_o`.
- R2: While `rst` is high at a clock edge, `row_en_o` and `col_o` become all zero, and the row, slot and divider counters return to zero. The outputs are registered. The first edge after reset is released shows row 0, slot 0, divider 0. Every later output reflects the counter state and the inputs that were present at the previous edge.
- R3: Each character code is 8 bits wide, and digit n occupies `chars_i[8n+7:8n]`. If bit 7 is 0, bits 6..0 go out as the symbol on `glyph_code_o[7n+6:7n]`, and the 5 dots returned on `glyph_dots_i[5n+4:5n]` appear on `col_o[5n+4:5n]`. The leftmost column is the most significant bit.
- R4: A character whose bit 7 is 1 takes its dots from `cg_dots_i[5n+4:5n]`. Its bits 3..0 are presented as the entry on `cg_index_o[4n+3:4n]`.
- R5: Columns are lit only for the first L clocks of each row slot and are zero for the rest. L is 32, 26, 17, 13, 9, 6, 4 or 0 for brightness codes 0 to 7.
- R6: Brightness code 7 forces every column output to zero.
- R7: The divider counts 0 to BLINK_PERIOD-1 (28672) and then wraps. The dark phase is the second half, from BLINK_PERIOD/2 onward.
- R8: In the dark phase, digit n shows zero columns when `flash_en_i` is 1 and `flash_mask_i[n]` is 1. In the light phase the flash setting has no effect.
- R9: When `flash_en_i` is 0, `flash_mask_i` has no effect on any output.
- R10: When `blink_en_i` is 1, all eight digits show zero columns in the dark phase, whatever the flash settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| bright_i | input | 3 | Brightness code, 0 is brightest, 7 is blank |
| flash_en_i | input | 1 | Enables the per-digit flash attribute |
| blink_en_i | input | 1 | Enables blinking of the whole display |
| flash_mask_i | input | 8 | Flash attribute bit per digit |
| chars_i | input | 64 | Eight character codes (tag bit 7, symbol 6..0) |
| glyph_code_o | output | 56 | Symbol per digit for the built-in glyph lookup |
| glyph_row_o | output | 3 | Active row for the built-in glyph lookup |
| glyph_dots_i | input | 40 | Built-in glyph dots per digit |
| cg_index_o | output | 32 | Custom-glyph entry per digit |
| cg_row_o | output | 3 | Active row for the custom-glyph memory |
| cg_dots_i | input | 40 | Custom-glyph dots per digit |
| row_en_o | output | 7 | One-hot row enable |
| col_o | output | 40 | Column dots, digit n in bits 5n+4..5n |

## Verification
The bench keeps eight digits, seven rows and 32-clock slots, so the brightness table is compared at its exact clock counts. It sets BLINK_PERIOD to 896 rather than 28672. That makes the dark half 448 clocks, and the flash and blink phases then change many times within a short run, giving many entries into and exits from the dark half. Because 896 is four refresh periods, the divider wrap and the row wrap coincide. A mid-run reset tests the return of all counters to phase zero.

// File: rtl/dotscan_pkg.sv
package dotscan_pkg;

    localparam int CHAR_W   = 8;
    localparam int SYM_W    = 7;
    localparam int CG_IDX_W = 4;
    localparam int GLYPH_W  = 5;
    localparam int BRIGHT_W = 3;

    typedef struct packed {
        logic             custom;
        logic [SYM_W-1:0] sym;
    } char_t;

    typedef enum logic {
        SRC_BUILTIN = 1'b0,
        SRC_CUSTOM  = 1'b1
    } glyph_src_e;

    // Lit clocks per row slot for a brightness code, rounded to nearest
    function automatic int lit_clocks(input logic [BRIGHT_W-1:0] code, input int slot_len);
        int pct;
        case (code)
            3'd0:    pct = 100;
            3'd1:    pct = 80;
            3'd2:    pct = 53;
            3'd3:    pct = 40;
            3'd4:    pct = 27;
            3'd5:    pct = 20;
            3'd6:    pct = 13;
            default: pct = 0;
        endcase
        return (slot_len * pct + 50) / 100;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int ROWS         = 7,
    parameter int SLOT_CLKS    = 32,
    parameter int BLINK_PERIOD = 28672,
    localparam int ROW_W       = $clog2(ROWS),
    localparam int SLOT_W      = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ROW_W-1:0]  row_idx_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              dark_o
);
    localparam int DIV_W = $clog2(BLINK_PERIOD);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_CLKS - 1);
    localparam logic [DIV_W-1:0]  LAST_DIV  = DIV_W'(BLINK_PERIOD - 1);
    localparam logic [DIV_W-1:0]  HALF_DIV  = DIV_W'(BLINK_PERIOD / 2);

    logic [ROW_W-1:0]  row_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DIV_W-1:0]  div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            slot_q <= '0;
            div_q  <= '0;
        end else begin
            if (slot_q == LAST_SLOT) begin
                slot_q <= '0;
                row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
            div_q <= (div_q == LAST_DIV) ? '0 : div_q + 1'b1;
        end
    end

    assign row_idx_o  = row_q;
    assign slot_idx_o = slot_q;
    assign dark_o     = (div_q >= HALF_DIV);

    assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (slot_q == LAST_SLOT && row_q == LAST_ROW) |=> (slot_q == '0 && row_q == '0));

    assert_row_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (slot_q != LAST_SLOT) |=> $stable(row_q));

    assert_div_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (div_q == LAST_DIV) |=> (div_q == '0 && !dark_o));

endmodule

// File: rtl/digit_gate.sv
module digit_gate
    import dotscan_pkg::*;
(
    input  logic               src_custom_i,
    input  logic [GLYPH_W-1:0] builtin_dots_i,
    input  logic [GLYPH_W-1:0] custom_dots_i,
    input  logic               lit_i,
    input  logic               dark_i,
    input  logic               flash_bit_i,
    input  logic               flash_en_i,
    input  logic               blink_en_i,
    output logic [GLYPH_W-1:0] dots_o
);
    glyph_src_e         src;
    logic [GLYPH_W-1:0] picked;
    logic               hide;

    always_comb begin
        src    = glyph_src_e'(src_custom_i);
        picked = (src == SRC_CUSTOM) ? custom_dots_i : builtin_dots_i;
        hide   = !lit_i || (dark_i && (blink_en_i || (flash_en_i && flash_bit_i)));
        dots_o = hide ? '0 : picked;
    end

endmodule

// File: rtl/dotscan_engine.sv
module dotscan_engine
    import dotscan_pkg::*;
#(
    parameter int DIGITS       = 8,
    parameter int ROWS         = 7,
    parameter int SLOT_CLKS    = 32,
    parameter int BLINK_PERIOD = 28672,
    localparam int ROW_W       = $clog2(ROWS),
    localparam int SLOT_W      = $clog2(SLOT_CLKS),
    localparam int COL_W       = DIGITS * GLYPH_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BRIGHT_W-1:0]         bright_i,
    input  logic                        flash_en_i,
    input  logic                        blink_en_i,
    input  logic [DIGITS-1:0]           flash_mask_i,
    input  logic [DIGITS*CHAR_W-1:0]    chars_i,
    output logic [DIGITS*SYM_W-1:0]     glyph_code_o,
    output logic [ROW_W-1:0]            glyph_row_o,
    input  logic [COL_W-1:0]            glyph_dots_i,
    output logic [DIGITS*CG_IDX_W-1:0]  cg_index_o,
    output logic [ROW_W-1:0]            cg_row_o,
    input  logic [COL_W-1:0]            cg_dots_i,
    output logic [ROWS-1:0]             row_en_o,
    output logic [COL_W-1:0]            col_o
);
    logic [ROW_W-1:0]  row_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              dark;
    logic [SLOT_W:0]   lit_limit;
    logic              lit;
    logic [ROWS-1:0]   row_en_d;
    logic [COL_W-1:0]  col_d;
    logic [ROWS-1:0]   row_en_q;
    logic [COL_W-1:0]  col_q;

    scan_timer #(
        .ROWS         (ROWS),
        .SLOT_CLKS    (SLOT_CLKS),
        .BLINK_PERIOD (BLINK_PERIOD)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .row_idx_o  (row_idx),
        .slot_idx_o (slot_idx),
        .dark_o     (dark)
    );

    assign glyph_row_o = row_idx;
    assign cg_row_o    = row_idx;

    always_comb begin
        lit_limit = (SLOT_W + 1)'(lit_clocks(bright_i, SLOT_CLKS));
        lit       = ({1'b0, slot_idx} < lit_limit);
        row_en_d  = ROWS'(1) << row_idx;
    end

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        char_t ch;
        assign ch = chars_i[d*CHAR_W +: CHAR_W];
        assign glyph_code_o[d*SYM_W +: SYM_W]       = ch.sym;
        assign cg_index_o[d*CG_IDX_W +: CG_IDX_W]   = ch.sym[CG_IDX_W-1:0];

        digit_gate u_gate (
            .src_custom_i   (ch.custom),
            .builtin_dots_i (glyph_dots_i[d*GLYPH_W +: GLYPH_W]),
            .custom_dots_i  (cg_dots_i[d*GLYPH_W +: GLYPH_W]),
            .lit_i          (lit),
            .dark_i         (dark),
            .flash_bit_i    (flash_mask_i[d]),
            .flash_en_i     (flash_en_i),
            .blink_en_i     (blink_en_i),
            .dots_o         (col_d[d*GLYPH_W +: GLYPH_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_en_q <= '0;
            col_q    <= '0;
        end else begin
            row_en_q <= row_en_d;
            col_q    <= col_d;
        end
    end

    assign row_en_o = row_en_q;
    assign col_o    = col_q;

    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_en_o));

    assert_blank_code_R6: assert property (@(posedge clk) disable iff (rst)
        (bright_i == 3'd7) |=> (col_o == '0));

    assert_blink_dark_R10: assert property (@(posedge clk) disable iff (rst)
        (blink_en_i && dark) |=> (col_o == '0));

endmodule

// File: tb/sim_dotscan_engine.sv
module sim_dotscan_engine;
    localparam int DIGITS = 8;
    localparam int ROWS   = 7;
    localparam int SLOT   = 32;
    localparam int PERIOD = 896;
    localparam int HALF   = PERIOD / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bright = '0;
    logic        flash_en = 1'b0;
    logic        blink_en = 1'b0;
    logic [7:0]  mask = '0;
    logic [63:0] chars = '0;
    logic [55:0] gcode;
    logic [2:0]  grow;
    logic [39:0] gdots;
    logic [31:0] cidx;
    logic [2:0]  crow;
    logic [39:0] cdots;
    logic [6:0]  row_en;
    logic [39:0] cols;
    logic [34:0] cg_mem [16];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [6:0]  exp_row;
    logic [39:0] exp_col;
    string       lbl_row;
    string       lbl_col;

    always #4 clk = ~clk;

    dotscan_engine #(
        .DIGITS(DIGITS), .ROWS(ROWS), .SLOT_CLKS(SLOT), .BLINK_PERIOD(PERIOD)
    ) u0 (
        .clk(clk), .rst(rst), .bright_i(bright), .flash_en_i(flash_en),
        .blink_en_i(blink_en), .flash_mask_i(mask), .chars_i(chars),
        .glyph_code_o(gcode), .glyph_row_o(grow), .glyph_dots_i(gdots),
        .cg_index_o(cidx), .cg_row_o(crow), .cg_dots_i(cdots),
        .row_en_o(row_en), .col_o(cols)
    );

    function automatic logic [4:0] rom_stub(input logic [6:0] c, input logic [2:0] r);
        int v;
        v = int'(c) * 5 + int'(r) * 11 + int'(c) / 8;
        return v[4:0];
    endfunction

    function automatic logic [4:0] cg_stub(input logic [3:0] e, input logic [2:0] r);
        logic [34:0] w;
        w = cg_mem[e];
        if (r > 3'd6) return 5'd0;
        return w[5*r +: 5];
    endfunction

    always_comb begin
        for (int g = 0; g < DIGITS; g++) begin
            gdots[5*g +: 5] = rom_stub(gcode[7*g +: 7], grow);
            cdots[5*g +: 5] = cg_stub(cidx[4*g +: 4], crow);
        end
    end

    function automatic int lit_of(input logic [2:0] code);
        case (code)
            3'd0: return 32;
            3'd1: return 26;
            3'd2: return 17;
            3'd3: return 13;
            3'd4: return 9;
            3'd5: return 6;
            3'd6: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic compute(input int t);
        int  row, slot, div;
        bit  dark, lit, any_custom;
        logic [7:0] ch;
        logic [4:0] dots;
        row  = (t / SLOT) % ROWS;
        slot = t % SLOT;
        div  = t % PERIOD;
        dark = (div >= HALF);
        lit  = (slot < lit_of(bright));
        any_custom = 1'b0;
        exp_row = 7'(1) << row;
        for (int n = 0; n < DIGITS; n++) begin
            ch = chars[8*n +: 8];
            if (ch[7]) any_custom = 1'b1;
            dots = ch[7] ? cg_stub(ch[3:0], 3'(row)) : rom_stub(ch[6:0], 3'(row));
            if (!lit || (dark && (blink_en || (flash_en && mask[n])))) dots = '0;
            exp_col[5*n +: 5] = dots;
        end
        lbl_row = (t == 0) ? "R2" : "R1";
        if (t == 0)                                      lbl_col = "R2";
        else if (bright == 3'd7)                         lbl_col = "R6";
        else if (div == 0 || div == HALF)                lbl_col = "R7";
        else if (dark && blink_en)                       lbl_col = "R10";
        else if (dark && flash_en && mask != 0)          lbl_col = "R8";
        else if (dark && !flash_en && mask != 0)         lbl_col = "R9";
        else if (!lit)                                   lbl_col = "R5";
        else if (any_custom)                             lbl_col = "R4";
        else                                             lbl_col = "R3";
    endtask

    task automatic check_now();
        checks++;
        if (row_en !== exp_row) begin
            fails++;
            $display("FAIL %s row_en actual=%b expected=%b", lbl_row, row_en, exp_row);
        end
        checks++;
        if (cols !== exp_col) begin
            fails++;
            $display("FAIL %s col actual=%h expected=%h", lbl_col, cols, exp_col);
        end
    endtask

    task automatic set_segment(input int seg);
        logic [63:0] c;
        bit          tag_mode;
        c = {$urandom, $urandom};
        tag_mode = 1'($urandom % 2);
        case (seg)
            0: begin bright = 3'd0; flash_en = 0; blink_en = 0; mask = 8'h00; tag_mode = 0; end
            1: begin bright = 3'd7; flash_en = 1; blink_en = 0; mask = 8'hFF; end
            2: begin bright = 3'd0; flash_en = 1; blink_en = 1; mask = 8'h3C; end
            3: begin bright = 3'd1; flash_en = 1; blink_en = 0; mask = 8'hA5; end
            4: begin bright = 3'd0; flash_en = 0; blink_en = 0; mask = 8'hFF; tag_mode = 0; end
            5: begin bright = 3'd3; flash_en = 0; blink_en = 0; mask = 8'h00;
                     c = c | 64'h8080_8080_8080_8080; tag_mode = 1; end
            default: begin
                bright   = 3'($urandom_range(0, 7));
                flash_en = 1'($urandom % 2);
                blink_en = (($urandom % 4) == 0);
                mask     = 8'($urandom);
            end
        endcase
        if (!tag_mode) c = c & 64'h7F7F_7F7F_7F7F_7F7F;
        chars = c;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'h5EED_2024));
        for (int e = 0; e < 16; e++) cg_mem[e] = 35'({$urandom, $urandom});
        exp_row = '0;
        exp_col = '0;
        lbl_row = "R2";
        lbl_col = "R2";
        t = 0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int seg = 0; seg < 40; seg++) begin
            set_segment(seg);
            for (int c = 0; c < 500; c++) begin
                if (c == 250 && seg > 5) chars = {$urandom, $urandom};
                check_now();
                if (seg == 20 && c < 3) begin
                    rst = 1'b1;
                    exp_row = '0;
                    exp_col = '0;
                    lbl_row = "R2";
                    lbl_col = "R2";
                    t = 0;
                end else begin
                    rst = 1'b0;
                    compute(t);
                    t++;
                end
                @(negedge clk);
            end
        end
        check_now();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule